// File: doc/BRIEF.md
# IPv4 Fast-Path Header Processor

This block sits between a queue of inbound packet headers and the forwarding logic of a router line card. Each request carries a 20-byte IPv4 header and a packet identifier. The block checks the header for sanity and looks the destination up through a single-cycle route lookup port. It then decides whether the packet can take the fast path or must be handed to a slower general-purpose processor. On the fast path it lowers the time-to-live by one and patches the header checksum incrementally. Packets addressed to the router itself pass through with their header untouched.

The reply carries the rewritten header, the identifier, a destination tag, a cast type, a slow-path flag and an error flag. Any unusual packet is diverted rather than handled here: options, multicast, oversize, route misses and expiring TTL all go to the slow path. The received checksum is deliberately never verified. Both sides use valid/ready handshakes. A single register stage gives one cycle of latency, accepts up to one header per cycle and keeps arrival order.

Header layout used throughout (bit 159 is the first bit on the wire): version [159:156], header length in 32-bit words [155:152], total length in bytes [143:128], TTL [95:88], checksum [79:64], destination address [31:0]. Cast type encoding: 2'b00 unicast, 2'b01 multicast, 2'b10 local delivery.

Top module: `ipv4_fastpath`

## Requirements
- R1: A header whose version field is not 4 is replied with outSlow=1 and outError=0, its header unchanged and destination tag 0.
- R2: A version-4 header whose length field is below 5, or whose total length is below four times the length field, is replied with outError=1 and outSlow=0, header unchanged and tag 0.
- R3: A version-4 header with a sane length and a length field above 5 (options present) is replied with outSlow=1.
- R4: A destination whose first octet is 224 to 239 gives cast type 2'b01 and, once R1 to R3 pass, outSlow=1.
- R5: A total length above the MTU parameter (default 1500) sends the packet to the slow path; a length equal to the MTU does not.
- R6: A destination equal to the LOCAL_ADDR parameter gives cast 2'b10 and outSlow=0, leaves TTL and checksum unchanged whatever the TTL, and returns the LOCAL_TAG parameter as the tag.
- R7: A route lookup miss for a non-local, non-multicast destination sends the packet to the slow path; every slow or error reply carries tag 0.
- R8: A non-local unicast packet with TTL 0 or 1 is sent to the slow path.
- R9: A forwarded packet leaves with TTL one lower and a checksum equal to the old checksum plus 0x0100 with end-around carry. All other header bits are unchanged, and the tag is the lookup tag. The received checksum is not checked, so a wrong one is forwarded the same way.
- R10: inReady is high exactly when the output register is empty or being drained. Replies leave in arrival order with the packet identifier preserved, and they hold stable while outValid is high and outReady is low.
- R11: After reset outValid is 0 and inReady is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request header valid |
| inReady | output | 1 | Request accepted this cycle when high with inValid |
| inHdr | input | 160 | 20-byte IPv4 header |
| inPktId | input | ID_W | Inbound packet identifier |
| lkAddr | output | 32 | Destination address presented to the route lookup |
| lkHit | input | 1 | Lookup hit for lkAddr, same cycle |
| lkTag | input | TAG_W | Next-hop tag for lkAddr, same cycle |
| outValid | output | 1 | Reply valid |
| outReady | input | 1 | Reply consumer ready |
| outHdr | output | 160 | Header after rewrite |
| outPktId | output | ID_W | Outbound packet identifier |
| outDestTag | output | TAG_W | Destination tag |
| outCast | output | 2 | Cast type |
| outSlow | output | 1 | Packet must go to the slow path |
| outError | output | 1 | Header failed the length sanity checks |

## Verification
The assertions watch every cycle for several properties. Stalled replies must not change, and the input must not be accepted while the output register is blocked. Error replies are never marked slow, and multicast is never forwarded fast. Forwarded TTL is never zero. A fast-path rewrite of a header that arrived with a correct checksum must leave with a correct checksum. Only the bench scenarios can show the decision priority between overlapping conditions and the exact boundaries of the length, MTU, multicast and TTL checks. They also cover the exact checksum value for every TTL and for bad input checksums, and order keeping under back-pressure.

// File: rtl/fp_pkg.sv
package fp_pkg;

  localparam int HDR_W = 160;

  // header field positions (wire order, first byte in the top bits)
  localparam int VER_LSB  = 156;
  localparam int IHL_LSB  = 152;
  localparam int TLEN_LSB = 128;
  localparam int TTL_LSB  = 88;
  localparam int CSUM_LSB = 64;
  localparam int DST_LSB  = 0;

  typedef enum logic [1:0] {
    CAST_UNI   = 2'b00,
    CAST_MC    = 2'b01,
    CAST_LOCAL = 2'b10
  } castE;

  typedef struct packed {
    logic [3:0]  ver;
    logic [3:0]  ihl;
    logic [15:0] totLen;
    logic [7:0]  ttl;
    logic [31:0] dst;
    logic        lkHit;
  } hdrFieldsT;

  typedef struct packed {
    logic load;
    logic decTtl;
    logic slow;
    logic err;
    logic useLkTag;
    logic useLocalTag;
    castE cast;
  } ctrlStrobeT;

endpackage

// File: rtl/fp_datapath.sv
module fp_datapath
  import fp_pkg::*;
#(
  parameter int ID_W = 8,
  parameter int TAG_W = 8,
  parameter logic [TAG_W-1:0] LOCAL_TAG = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobeT       strobe,
  input  logic [HDR_W-1:0] inHdr,
  input  logic [ID_W-1:0]  inPktId,
  input  logic             lkHit,
  input  logic [TAG_W-1:0] lkTag,
  output hdrFieldsT        fields,
  output logic [HDR_W-1:0] outHdr,
  output logic [ID_W-1:0]  outPktId,
  output logic [TAG_W-1:0] outDestTag,
  output logic [1:0]       outCast,
  output logic             outSlow,
  output logic             outError
);

  localparam int WORDS = HDR_W / 16;

  logic [7:0]       oldTtl;
  logic [15:0]      oldCsum;
  logic [16:0]      csumSum;
  logic [15:0]      newCsum;
  logic [HDR_W-1:0] rewHdr;
  logic [TAG_W-1:0] nextTag;

  always_comb begin
    fields.ver    = inHdr[VER_LSB +: 4];
    fields.ihl    = inHdr[IHL_LSB +: 4];
    fields.totLen = inHdr[TLEN_LSB +: 16];
    fields.ttl    = inHdr[TTL_LSB +: 8];
    fields.dst    = inHdr[DST_LSB +: 32];
    fields.lkHit  = lkHit;
  end

  // incremental one's-complement update: TTL byte (high byte of its word) drops by one
  always_comb begin
    oldTtl  = inHdr[TTL_LSB +: 8];
    oldCsum = inHdr[CSUM_LSB +: 16];
    csumSum = {1'b0, oldCsum} + 17'h00100;
    newCsum = csumSum[15:0] + {15'd0, csumSum[16]};
    rewHdr  = inHdr;
    if (strobe.decTtl) begin
      rewHdr[TTL_LSB +: 8]   = oldTtl - 8'd1;
      rewHdr[CSUM_LSB +: 16] = newCsum;
    end
  end

  always_comb begin
    if (strobe.useLkTag)         nextTag = lkTag;
    else if (strobe.useLocalTag) nextTag = LOCAL_TAG;
    else                         nextTag = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outHdr     <= '0;
      outPktId   <= '0;
      outDestTag <= '0;
      outCast    <= CAST_UNI;
      outSlow    <= 1'b0;
      outError   <= 1'b0;
    end else if (strobe.load) begin
      outHdr     <= rewHdr;
      outPktId   <= inPktId;
      outDestTag <= nextTag;
      outCast    <= strobe.cast;
      outSlow    <= strobe.slow;
      outError   <= strobe.err;
    end
  end

  function automatic logic csumGood(input logic [HDR_W-1:0] h);
    logic [31:0] acc;
    acc = '0;
    for (int i = 0; i < WORDS; i++) acc = acc + {16'd0, h[i*16 +: 16]};
    acc = {16'd0, acc[15:0]} + {16'd0, acc[31:16]};
    acc = {16'd0, acc[15:0]} + {16'd0, acc[31:16]};
    return acc[15:0] == 16'hFFFF;
  endfunction

  AST_CSUM_STAYS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load && strobe.decTtl && csumGood(inHdr) |=> csumGood(outHdr)); // R9

  AST_TTL_DROPS_ONE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load && strobe.decTtl |=> outHdr[TTL_LSB +: 8] == $past(inHdr[TTL_LSB +: 8]) - 8'd1); // R9

endmodule

// File: rtl/fp_ctrl.sv
module fp_ctrl
  import fp_pkg::*;
#(
  parameter logic [31:0] LOCAL_ADDR = 32'hC0A8_0001,
  parameter int MTU = 1500
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       outReady,
  input  hdrFieldsT  fields,
  output logic       inReady,
  output logic       outValid,
  output ctrlStrobeT strobe
);

  localparam logic [15:0] MTU_LIM = 16'(MTU);

  logic verBad, lenBad, hasOpts, isMc, tooBig, isLocal, ttlLow;
  logic [15:0] hdrBytes;

  always_comb begin
    hdrBytes = {10'd0, fields.ihl, 2'b00};
    verBad   = fields.ver != 4'd4;
    lenBad   = (fields.ihl < 4'd5) || (fields.totLen < hdrBytes);
    hasOpts  = fields.ihl > 4'd5;
    isMc     = (fields.dst[31:24] >= 8'd224) && (fields.dst[31:24] <= 8'd239);
    tooBig   = fields.totLen > MTU_LIM;
    isLocal  = fields.dst == LOCAL_ADDR;
    ttlLow   = fields.ttl <= 8'd1;
  end

  assign inReady = !outValid || outReady;

  always_comb begin
    strobe             = '0;
    strobe.load        = inValid && inReady;
    strobe.cast        = isMc ? CAST_MC : (isLocal ? CAST_LOCAL : CAST_UNI);
    if (verBad)                         strobe.slow = 1'b1;
    else if (lenBad)                    strobe.err  = 1'b1;
    else if (hasOpts || isMc || tooBig) strobe.slow = 1'b1;
    else if (isLocal)                   strobe.useLocalTag = 1'b1;
    else if (!fields.lkHit || ttlLow)   strobe.slow = 1'b1;
    else begin
      strobe.decTtl   = 1'b1;
      strobe.useLkTag = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            outValid <= 1'b0;
    else if (strobe.load) outValid <= 1'b1;
    else if (outReady)    outValid <= 1'b0;
  end

  AST_NO_ACCEPT_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |-> !strobe.load); // R10

  AST_NEVER_ERR_AND_SLOW: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |-> !(strobe.err && strobe.slow)); // R2

  AST_LOCAL_KEEPS_TTL: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load && isLocal |-> !strobe.decTtl); // R6

endmodule

// File: rtl/ipv4_fastpath.sv
module ipv4_fastpath
  import fp_pkg::*;
#(
  parameter int ID_W = 8,
  parameter int TAG_W = 8,
  parameter logic [31:0] LOCAL_ADDR = 32'hC0A8_0001,
  parameter logic [TAG_W-1:0] LOCAL_TAG = '1,
  parameter int MTU = 1500
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic [159:0]     inHdr,
  input  logic [ID_W-1:0]  inPktId,
  output logic [31:0]      lkAddr,
  input  logic             lkHit,
  input  logic [TAG_W-1:0] lkTag,
  output logic             outValid,
  input  logic             outReady,
  output logic [159:0]     outHdr,
  output logic [ID_W-1:0]  outPktId,
  output logic [TAG_W-1:0] outDestTag,
  output logic [1:0]       outCast,
  output logic             outSlow,
  output logic             outError
);

  hdrFieldsT  fields;
  ctrlStrobeT strobe;

  assign lkAddr = inHdr[DST_LSB +: 32];

  fp_ctrl #(.LOCAL_ADDR(LOCAL_ADDR), .MTU(MTU)) ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .outReady(outReady),
    .fields(fields), .inReady(inReady), .outValid(outValid), .strobe(strobe)
  );

  fp_datapath #(.ID_W(ID_W), .TAG_W(TAG_W), .LOCAL_TAG(LOCAL_TAG)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inHdr(inHdr), .inPktId(inPktId),
    .lkHit(lkHit), .lkTag(lkTag), .fields(fields), .outHdr(outHdr),
    .outPktId(outPktId), .outDestTag(outDestTag), .outCast(outCast),
    .outSlow(outSlow), .outError(outError)
  );

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outHdr) && $stable(outPktId)
      && $stable(outDestTag) && $stable(outSlow) && $stable(outError)); // R10

  AST_MC_NEVER_FAST: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outCast == 2'b01 && !outError |-> outSlow); // R4

  AST_FWD_TTL_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outCast == 2'b00 && !outSlow && !outError |-> outHdr[TTL_LSB +: 8] != 8'd0); // R8

endmodule

// File: tb/ipv4_fastpath_tb_top.sv
module ipv4_fastpath_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] LOCAL_ADDR = 32'hC0A8_0001;
  localparam logic [7:0] LOCAL_TAG = 8'hFF;
  localparam int MTU = 1500;
  localparam logic [31:0] DST_HIT = 32'h0A01_0203;
  localparam logic [31:0] DST_MISS = 32'h0A01_0103;

  logic clk = 0, rstN = 0;
  logic inValid = 0, inReady, outValid, outReady = 1, lkHit, outSlow, outError;
  logic [159:0] inHdr = '0, outHdr;
  logic [7:0] inPktId = '0, lkTag, outPktId, outDestTag;
  logic [31:0] lkAddr;
  logic [1:0] outCast;

  always #(CLK_PERIOD/2) clk = ~clk;

  // route lookup model: address bit 8 set means miss
  assign lkHit = ~lkAddr[8];
  assign lkTag = lkAddr[7:0] ^ 8'h5A;

  ipv4_fastpath #(.LOCAL_ADDR(LOCAL_ADDR), .LOCAL_TAG(LOCAL_TAG), .MTU(MTU)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inHdr(inHdr),
    .inPktId(inPktId), .lkAddr(lkAddr), .lkHit(lkHit), .lkTag(lkTag),
    .outValid(outValid), .outReady(outReady), .outHdr(outHdr), .outPktId(outPktId),
    .outDestTag(outDestTag), .outCast(outCast), .outSlow(outSlow), .outError(outError)
  );

  typedef struct {
    logic [159:0] hdr;
    logic [7:0]   id;
    logic [7:0]   tag;
    logic [1:0]   cast;
    logic         slow;
    logic         err;
    string        req;
  } replyT;

  logic [159:0] stim[$];
  replyT expQ[$];
  int nChecks = 0, nFails = 0;
  bit done = 0;

  task automatic check(bit ok, string req, string what, logic [191:0] act, logic [191:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [159:0] mkHdr(logic [3:0] ver, logic [3:0] ihl, logic [15:0] tl,
                                         logic [7:0] ttl, logic [31:0] dst, bit goodCsum);
    logic [159:0] h;
    logic [31:0] acc;
    h = {ver, ihl, 8'h00, tl, 16'h1234, 16'h4000, ttl, 8'd17, 16'h0000, 32'hAC10_0A05, dst};
    acc = '0;
    for (int i = 0; i < 10; i++) acc = acc + {16'd0, h[i*16 +: 16]};
    acc = {16'd0, acc[15:0]} + {16'd0, acc[31:16]};
    acc = {16'd0, acc[15:0]} + {16'd0, acc[31:16]};
    h[79:64] = goodCsum ? ~acc[15:0] : ~acc[15:0] ^ 16'h0F0F;
    return h;
  endfunction

  function automatic replyT model(logic [159:0] h, logic [7:0] id);
    replyT r;
    logic [3:0] ver = h[159:156], ihl = h[155:152];
    logic [15:0] tl = h[143:128];
    logic [7:0] ttl = h[95:88];
    logic [31:0] dst = h[31:0];
    bit mc = dst[31:24] >= 224 && dst[31:24] <= 239;
    int s;
    r.hdr = h; r.id = id; r.tag = 8'h00; r.slow = 0; r.err = 0;
    r.cast = mc ? 2'b01 : (dst == LOCAL_ADDR ? 2'b10 : 2'b00);
    if (ver != 4)                               begin r.slow = 1; r.req = "R1"; end
    else if (ihl < 5 || int'(tl) < int'(ihl)*4) begin r.err = 1; r.req = "R2"; end
    else if (ihl > 5)                           begin r.slow = 1; r.req = "R3"; end
    else if (mc)                                begin r.slow = 1; r.req = "R4"; end
    else if (int'(tl) > MTU)                    begin r.slow = 1; r.req = "R5"; end
    else if (dst == LOCAL_ADDR)                 begin r.tag = LOCAL_TAG; r.req = "R6"; end
    else if (dst[8])                            begin r.slow = 1; r.req = "R7"; end
    else if (ttl <= 1)                          begin r.slow = 1; r.req = "R8"; end
    else begin
      r.req = "R9";
      r.hdr[95:88] = ttl - 8'd1;
      s = int'(h[79:64]) + 32'h100;
      if (s > 32'hFFFF) s = (s & 32'hFFFF) + 1;
      r.hdr[79:64] = 16'(s);
      r.tag = dst[7:0] ^ 8'h5A;
    end
    return r;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin : main
    int idx, cyc;
    bit snapV;
    logic [191:0] snap;
    // R1 sweep of version field
    for (int v = 0; v < 16; v++) stim.push_back(mkHdr(4'(v), 4'd5, 16'd100, 8'd64, DST_HIT, 1));
    // R2/R3 sweep of header length with total length on both sides of the bound
    for (int l = 0; l < 16; l++) begin
      stim.push_back(mkHdr(4'd4, 4'(l), 16'(l*4), 8'd64, DST_HIT, 1));
      stim.push_back(mkHdr(4'd4, 4'(l), 16'(l*4 - 1), 8'd64, DST_HIT, 1));
    end
    // R4 first-octet sweep around the multicast range
    for (int o = 220; o < 244; o++) stim.push_back(mkHdr(4'd4, 4'd5, 16'd100, 8'd64, {8'(o), 24'h010203}, 1));
    // R5 MTU boundary
    stim.push_back(mkHdr(4'd4, 4'd5, 16'(MTU - 1), 8'd64, DST_HIT, 1));
    stim.push_back(mkHdr(4'd4, 4'd5, 16'(MTU), 8'd64, DST_HIT, 1));
    stim.push_back(mkHdr(4'd4, 4'd5, 16'(MTU + 1), 8'd64, DST_HIT, 1));
    stim.push_back(mkHdr(4'd4, 4'd5, 16'hFFFF, 8'd64, DST_HIT, 1));
    // R6 local with several TTLs, and local with options
    for (int t = 0; t < 4; t++) stim.push_back(mkHdr(4'd4, 4'd5, 16'd60, 8'(t), LOCAL_ADDR, 1));
    stim.push_back(mkHdr(4'd4, 4'd6, 16'd60, 8'd9, LOCAL_ADDR, 1));
    // R7 misses
    for (int t = 0; t < 4; t++) stim.push_back(mkHdr(4'd4, 4'd5, 16'd60, 8'(t*60), DST_MISS | 32'(t << 16), 1));
    // R8/R9 full TTL sweep on a hit, good and bad checksum
    for (int t = 0; t < 256; t++) stim.push_back(mkHdr(4'd4, 4'd5, 16'd40 + 16'(t), 8'(t), DST_HIT ^ 32'(t), t[0]));

    // R11 reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(outValid == 0, "R11", "outValid in reset", 192'(outValid), 192'd0);
    rstN = 1;
    @(negedge clk);
    check(outValid == 0 && inReady == 1, "R11", "valid/ready after reset",
          192'({outValid, inReady}), 192'b01);

    idx = 0; cyc = 0; snapV = 0;
    while (idx < stim.size() || expQ.size() != 0) begin
      @(negedge clk);
      cyc++;
      outReady = (cyc < 200) ? 1'b1 : (cyc % 4 != 1 && cyc % 9 != 0);
      #1;
      if (snapV) begin
        check(outValid && {outHdr, outPktId, outDestTag, outCast, outSlow, outError} == snap[181:0],
              "R10", "stall hold", 192'({outHdr, outPktId, outDestTag}), snap);
        snapV = 0;
      end
      if (outValid) begin
        if (outReady) begin
          replyT e;
          if (expQ.size() == 0) begin
            check(0, "R10", "unexpected reply", 192'(outPktId), 192'd0);
          end else begin
            e = expQ.pop_front();
            check(outHdr == e.hdr && outPktId == e.id && outDestTag == e.tag && outCast == e.cast
                  && outSlow == e.slow && outError == e.err, e.req,
                  $sformatf("reply id=%0h hdr", e.id),
                  {outHdr[159:64], outPktId, outDestTag, 4'd0, outCast, outSlow, outError, 72'd0},
                  {e.hdr[159:64], e.id, e.tag, 4'd0, e.cast, e.slow, e.err, 72'd0});
          end
        end else begin
          snapV = 1;
          snap = 192'({outHdr, outPktId, outDestTag, outCast, outSlow, outError});
        end
      end
      check(inReady == (!outValid || outReady), "R10", "inReady rule",
            192'(inReady), 192'(!outValid || outReady));
      if (idx < stim.size() && !(cyc >= 200 && cyc % 7 == 3)) begin
        inValid = 1; inHdr = stim[idx]; inPktId = 8'(idx);
        #1;
        if (inReady) begin
          expQ.push_back(model(stim[idx], 8'(idx)));
          idx++;
        end
      end else begin
        inValid = 0;
      end
    end
    @(negedge clk);
    inValid = 0; outReady = 1;
    repeat (3) @(negedge clk);
    check(outValid == 0, "R10", "idle after drain", 192'(outValid), 192'd0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule